// File: doc/BRIEF.md
# Polyphase Scaler Coefficient Store

This block holds the filter coefficients of a polyphase video scaler. It has four banks: luma vertical (bank 0), chroma vertical (bank 1), luma horizontal (bank 2) and chroma horizontal (bank 3). Each bank has a 64-phase, 4-tap filter. Software first writes a select word naming a bank, a phase and a tap pair. It then writes one data word that carries an even-tap coefficient and an odd-tap coefficient, each with its own enable. Only phases 0 through 32 are stored. A read of phases 33 to 63 is built from the stored phase 64-p with the taps in reverse order.

Writes land in a shadow copy. A one-cycle commit pulse copies the shadow into the active copy, and the read port only ever sees the active copy. This lets a new filter set be loaded while the previous set stays in service. The coefficient memory has a power-gate handshake. Software sets a disable-gating control and waits for the status to report 0 (powered). A data write made while the memory is gated is dropped and raises a sticky error flag.

Top module: `coef_store`

## Requirements
- R1: A data write stores into the bank, phase and tap pair given by the most recent select write. Tap pair k holds taps 2k (even) and 2k+1 (odd). The bank encoding is 0 luma vertical, 1 chroma vertical, 2 luma horizontal, 3 chroma horizontal.
- R2: Within a data write, a coefficient whose enable is 0 is not stored, and the previously stored value at that tap is kept.
- R3: The read port returns only the active copy. Data writes do not change read results until a commit.
- R4: Pulsing `commitWr` in cycle k makes the active copy equal to the shadow at the edge of cycle k+1. A read issued in cycle k+1 still returns the old set, and a read issued in cycle k+2 returns the new set. The internal commit strobe lasts exactly one cycle.
- R5: `rdValid` is high in the cycle after `rdEn` and low otherwise. `rdCoef` is registered with one cycle of latency.
- R6: For a read phase p of 32 or less, `rdCoef[16t +: 16]` is tap t of stored phase p.
- R7: For a read phase p above 32, `rdCoef[16t +: 16]` is tap 3-t of stored phase 64-p.
- R8: After reset `pwrState` is 1 (gated). One cycle after the gating control is written to 1 it is still 1, and in the cycle after that it is 0. Writing the control to 0 returns it to 1 with the same delay.
- R9: A data write while `pwrState` is 1 is dropped and sets `errFlag` on the next edge. `errFlag` stays set until `errClr` is pulsed. A new error wins over a clear in the same cycle.
- R10: After reset every coefficient in both copies reads as 0, `errFlag` is 0 and `rdValid` is 0.
- R11: The banks are independent. A write to one bank leaves the same phase and pair of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selWrEn | input | 1 | Select word write strobe |
| selBank | input | 2 | Bank of the select word |
| selPhase | input | 6 | Phase of the select word (0..32 stored) |
| selPair | input | 1 | Tap pair index of the select word |
| dataWrEn | input | 1 | Data word write strobe |
| evenEn | input | 1 | Store the even coefficient |
| evenCoef | input | 16 | Even-tap coefficient |
| oddEn | input | 1 | Store the odd coefficient |
| oddCoef | input | 16 | Odd-tap coefficient |
| commitWr | input | 1 | Update-complete write, moves the shadow into the active copy |
| pwrDisWr | input | 1 | Write strobe for the gating-disable control |
| pwrDisVal | input | 1 | Value for the gating-disable control (1 = powered) |
| errClr | input | 1 | Clears the sticky error flag |
| rdEn | input | 1 | Read request |
| rdBank | input | 2 | Bank to read |
| rdPhase | input | 6 | Phase to read (0..63) |
| rdValid | output | 1 | Read data valid |
| rdCoef | output | 64 | Four tap coefficients, tap t at bits 16t+15:16t |
| pwrState | output | 1 | Memory power status, 0 = powered |
| errFlag | output | 1 | Sticky flag for writes made while the memory was gated |

## Verification
The stimulus table writes all four banks at phase 0, the last unique phase 32 and interior phases. It includes pairs with one enable low, which separates a correct write path from one that ignores the enables. Reads at phases 33 and 63 set against the stored phases 31 and 1 check both the mirror arithmetic and the tap reversal. A symmetric stored filter would hide a missing reversal, so those stored phases use distinct taps. A read issued in the cycle right after the commit pulse, followed by another read, pins down the exact cycle in which the swap happens. A write made while the memory is gated, and read back after a later commit, shows that the error path also drops the data.

// File: rtl/coef_store_pkg.sv
package coef_store_pkg;
  // Strobes from the control half to the storage half.
  typedef struct packed {
    logic wrEven;
    logic wrOdd;
    logic commit;
  } ctrl_strobe_t;
endpackage

// File: rtl/coef_store_ctrl.sv
module coef_store_ctrl
  import coef_store_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int PH_W   = 6,
  parameter int PAIR_W = 1,
  parameter int STORED = 33
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selWrEn,
  input  logic [BANK_W-1:0] selBank,
  input  logic [PH_W-1:0]   selPhase,
  input  logic [PAIR_W-1:0] selPair,
  input  logic              dataWrEn,
  input  logic              evenEn,
  input  logic              oddEn,
  input  logic              commitWr,
  input  logic              pwrDisWr,
  input  logic              pwrDisVal,
  input  logic              errClr,
  output ctrl_strobe_t      strobes,
  output logic [BANK_W-1:0] curBank,
  output logic [PH_W-1:0]   curPhase,
  output logic [PAIR_W-1:0] curPair,
  output logic              pwrState,
  output logic              errFlag
);
  logic pwrCtl;
  logic commitPend;
  logic inRange;
  logic accept;
  logic gatedWr;

  assign inRange = curPhase <= PH_W'(STORED - 1);
  assign accept  = dataWrEn && !pwrState && inRange;
  assign gatedWr = dataWrEn && pwrState;

  always_comb begin
    strobes.wrEven = accept && evenEn;
    strobes.wrOdd  = accept && oddEn;
    strobes.commit = commitPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBank    <= '0;
      curPhase   <= '0;
      curPair    <= '0;
      pwrCtl     <= 1'b0;
      pwrState   <= 1'b1;
      errFlag    <= 1'b0;
      commitPend <= 1'b0;
    end else begin
      if (selWrEn) begin
        curBank  <= selBank;
        curPhase <= selPhase;
        curPair  <= selPair;
      end
      if (pwrDisWr) pwrCtl <= pwrDisVal;
      pwrState   <= ~pwrCtl;
      errFlag    <= (errFlag && !errClr) || gatedWr;
      commitPend <= commitWr && !commitPend;
    end
  end
endmodule

// File: rtl/coef_store_mem.sv
module coef_store_mem
  import coef_store_pkg::*;
#(
  parameter int COEF_W     = 16,
  parameter int MAX_TAPS   = 4,
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PHASES = 64,
  parameter int BANK_W     = 2,
  parameter int PH_W       = 6,
  parameter int PAIR_W     = 1,
  parameter int STORED     = 33
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strobe_t               strobes,
  input  logic [BANK_W-1:0]          curBank,
  input  logic [PH_W-1:0]            curPhase,
  input  logic [PAIR_W-1:0]          curPair,
  input  logic [COEF_W-1:0]          evenCoef,
  input  logic [COEF_W-1:0]          oddCoef,
  input  logic                       rdEn,
  input  logic [BANK_W-1:0]          rdBank,
  input  logic [PH_W-1:0]            rdPhase,
  output logic                       rdValid,
  output logic [MAX_TAPS*COEF_W-1:0] rdCoef
);
  localparam int TAP_W = $clog2(MAX_TAPS);

  logic [COEF_W-1:0] shadowMem [NUM_BANKS][STORED][MAX_TAPS];
  logic [COEF_W-1:0] activeMem [NUM_BANKS][STORED][MAX_TAPS];

  logic [TAP_W-1:0] evenTap;
  logic [TAP_W-1:0] oddTap;
  assign evenTap = TAP_W'({curPair, 1'b0});
  assign oddTap  = TAP_W'({curPair, 1'b1});

  // Phases above the stored half read their mirror partner, taps reversed.
  localparam logic [PH_W:0] FULL = (PH_W+1)'(NUM_PHASES);
  logic              mirror;
  logic [PH_W-1:0]   srcPhase;
  logic [MAX_TAPS*COEF_W-1:0] rdNext;
  assign mirror   = rdPhase > PH_W'(STORED - 1);
  assign srcPhase = mirror ? PH_W'(FULL - {1'b0, rdPhase}) : rdPhase;

  for (genvar t = 0; t < MAX_TAPS; t++) begin : g_tap
    assign rdNext[t*COEF_W +: COEF_W] = mirror
      ? activeMem[rdBank][srcPhase][MAX_TAPS-1-t]
      : activeMem[rdBank][srcPhase][t];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int p = 0; p < STORED; p++)
          for (int t = 0; t < MAX_TAPS; t++) begin
            shadowMem[b][p][t] <= '0;
            activeMem[b][p][t] <= '0;
          end
      rdValid <= 1'b0;
      rdCoef  <= '0;
    end else begin
      if (strobes.wrEven) shadowMem[curBank][curPhase][evenTap] <= evenCoef;
      if (strobes.wrOdd)  shadowMem[curBank][curPhase][oddTap]  <= oddCoef;
      if (strobes.commit) activeMem <= shadowMem;
      rdValid <= rdEn;
      if (rdEn) rdCoef <= rdNext;
    end
  end
endmodule

// File: rtl/coef_store.sv
module coef_store
  import coef_store_pkg::*;
#(
  parameter int COEF_W     = 16,
  parameter int MAX_TAPS   = 4,
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PHASES = 64,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int PH_W      = $clog2(NUM_PHASES),
  localparam int PAIR_W    = (MAX_TAPS > 2) ? $clog2(MAX_TAPS/2) : 1,
  localparam int STORED    = NUM_PHASES/2 + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       selWrEn,
  input  logic [BANK_W-1:0]          selBank,
  input  logic [PH_W-1:0]            selPhase,
  input  logic [PAIR_W-1:0]          selPair,
  input  logic                       dataWrEn,
  input  logic                       evenEn,
  input  logic [COEF_W-1:0]          evenCoef,
  input  logic                       oddEn,
  input  logic [COEF_W-1:0]          oddCoef,
  input  logic                       commitWr,
  input  logic                       pwrDisWr,
  input  logic                       pwrDisVal,
  input  logic                       errClr,
  input  logic                       rdEn,
  input  logic [BANK_W-1:0]          rdBank,
  input  logic [PH_W-1:0]            rdPhase,
  output logic                       rdValid,
  output logic [MAX_TAPS*COEF_W-1:0] rdCoef,
  output logic                       pwrState,
  output logic                       errFlag
);
  ctrl_strobe_t      strobes;
  logic [BANK_W-1:0] curBank;
  logic [PH_W-1:0]   curPhase;
  logic [PAIR_W-1:0] curPair;

  coef_store_ctrl #(
    .BANK_W(BANK_W), .PH_W(PH_W), .PAIR_W(PAIR_W), .STORED(STORED)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .selWrEn(selWrEn), .selBank(selBank),
    .selPhase(selPhase), .selPair(selPair), .dataWrEn(dataWrEn),
    .evenEn(evenEn), .oddEn(oddEn), .commitWr(commitWr),
    .pwrDisWr(pwrDisWr), .pwrDisVal(pwrDisVal), .errClr(errClr),
    .strobes(strobes), .curBank(curBank), .curPhase(curPhase),
    .curPair(curPair), .pwrState(pwrState), .errFlag(errFlag)
  );

  coef_store_mem #(
    .COEF_W(COEF_W), .MAX_TAPS(MAX_TAPS), .NUM_BANKS(NUM_BANKS),
    .NUM_PHASES(NUM_PHASES), .BANK_W(BANK_W), .PH_W(PH_W),
    .PAIR_W(PAIR_W), .STORED(STORED)
  ) mem_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curBank(curBank),
    .curPhase(curPhase), .curPair(curPair), .evenCoef(evenCoef),
    .oddCoef(oddCoef), .rdEn(rdEn), .rdBank(rdBank), .rdPhase(rdPhase),
    .rdValid(rdValid), .rdCoef(rdCoef)
  );
endmodule

// File: rtl/coef_store_chk.sv
module coef_store_chk
  import coef_store_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         rdEn,
  input logic         rdValid,
  input logic         dataWrEn,
  input logic         commitWr,
  input logic         errClr,
  input logic         pwrState,
  input logic         errFlag,
  input ctrl_strobe_t strobes
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);  // R5
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);  // R5
  AST_GATED_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrEn && pwrState) |=> errFlag);  // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);  // R9
  AST_NO_GATED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEven || strobes.wrOdd) |-> !pwrState);  // R9
  AST_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> $past(commitWr));  // R4
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> !strobes.commit);  // R4
endmodule

bind coef_store coef_store_chk chk_i (.*);

// File: tb/coef_store_tb_top.sv
module coef_store_tb_top;
  typedef struct packed {
    logic [1:0]  bank;
    logic [5:0]  phase;
    logic        pair;
    logic        ee;
    logic [15:0] ev;
    logic        oe;
    logic [15:0] od;
  } wvec_t;

  localparam int NV = 9;
  localparam wvec_t WTAB [NV] = '{
    '{2'd0, 6'd0,  1'b0, 1'b1, 16'h1111, 1'b1, 16'h1112},
    '{2'd0, 6'd0,  1'b1, 1'b1, 16'h1113, 1'b1, 16'h1114},
    '{2'd1, 6'd5,  1'b0, 1'b1, 16'h2221, 1'b1, 16'h2222},
    '{2'd2, 6'd32, 1'b1, 1'b1, 16'h3333, 1'b1, 16'h3334},
    '{2'd3, 6'd20, 1'b0, 1'b1, 16'h4441, 1'b0, 16'h9999},
    '{2'd3, 6'd20, 1'b1, 1'b0, 16'h8888, 1'b1, 16'h4444},
    '{2'd2, 6'd31, 1'b0, 1'b1, 16'h5551, 1'b1, 16'h5552},
    '{2'd2, 6'd31, 1'b1, 1'b1, 16'h5553, 1'b1, 16'h5554},
    '{2'd1, 6'd1,  1'b1, 1'b1, 16'h6663, 1'b1, 16'h6664}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selWrEn = 0, dataWrEn = 0, evenEn = 0, oddEn = 0, commitWr = 0;
  logic pwrDisWr = 0, pwrDisVal = 0, errClr = 0, rdEn = 0, selPair = 0;
  logic [1:0]  selBank = 0, rdBank = 0;
  logic [5:0]  selPhase = 0, rdPhase = 0;
  logic [15:0] evenCoef = 0, oddCoef = 0;
  logic        rdValid, pwrState, errFlag;
  logic [63:0] rdCoef;

  int nTests = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 0;
  bit powered = 0;

  logic [15:0] mShd [4][33][4];
  logic [15:0] mAct [4][33][4];

  always #5 clk = ~clk;

  coef_store dut_i (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] expRead(input logic [1:0] b, input logic [5:0] p);
    logic [63:0] r;
    int sp;
    sp = (p > 32) ? 64 - p : p;
    for (int t = 0; t < 4; t++)
      r[t*16 +: 16] = (p > 32) ? mAct[b][sp][3-t] : mAct[b][sp][t];
    return r;
  endfunction

  task automatic wrPair(input wvec_t v);
    selWrEn = 1; selBank = v.bank; selPhase = v.phase; selPair = v.pair;
    tick();
    selWrEn = 0;
    dataWrEn = 1; evenEn = v.ee; evenCoef = v.ev; oddEn = v.oe; oddCoef = v.od;
    tick();
    dataWrEn = 0; evenEn = 0; oddEn = 0;
    if (powered) begin
      if (v.ee) mShd[v.bank][v.phase][{v.pair, 1'b0}] = v.ev;
      if (v.oe) mShd[v.bank][v.phase][{v.pair, 1'b1}] = v.od;
    end
  endtask

  task automatic rd(input logic [1:0] b, input logic [5:0] p, output logic [63:0] r);
    rdEn = 1; rdBank = b; rdPhase = p;
    tick();
    rdEn = 0;
    r = rdCoef;
  endtask

  task automatic commitPulse();
    commitWr = 1;
    tick();
    commitWr = 0;
  endtask

  task automatic applyModelCommit();
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 33; p++)
        for (int t = 0; t < 4; t++) mAct[b][p][t] = mShd[b][p][t];
  endtask

  initial begin
    logic [63:0] r;
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 33; p++)
        for (int t = 0; t < 4; t++) begin mShd[b][p][t] = '0; mAct[b][p][t] = '0; end

    repeat (3) tick();
    rstN = 1;
    tick();
    // R10 / R8 reset state
    check("R10 errFlag after reset", {63'd0, errFlag}, 64'd0);
    check("R10 rdValid after reset", {63'd0, rdValid}, 64'd0);
    check("R8 pwrState gated after reset", {63'd0, pwrState}, 64'd1);
    rd(2'd0, 6'd5, r);
    check("R10 coefficients zero after reset", r, 64'd0);
    check("R5 rdValid one cycle after rdEn", {63'd0, rdValid}, 64'd1);
    tick();
    check("R5 rdValid low without rdEn", {63'd0, rdValid}, 64'd0);

    // R9 gated write dropped, error sticky then cleared
    wrPair('{2'd0, 6'd7, 1'b0, 1'b1, 16'hDEAD, 1'b1, 16'hBEEF});
    check("R9 errFlag set by gated write", {63'd0, errFlag}, 64'd1);
    tick();
    check("R9 errFlag sticky", {63'd0, errFlag}, 64'd1);
    errClr = 1; tick(); errClr = 0;
    check("R9 errFlag cleared", {63'd0, errFlag}, 64'd0);

    // R8 power-up handshake timing
    pwrDisWr = 1; pwrDisVal = 1; tick(); pwrDisWr = 0;
    check("R8 status still gated one cycle after control", {63'd0, pwrState}, 64'd1);
    tick();
    check("R8 status powered two cycles after control", {63'd0, pwrState}, 64'd0);
    powered = 1;

    // Table walk: R1 R2 R11 writes
    for (int i = 0; i < NV; i++) wrPair(WTAB[i]);
    check("R9 no error on powered writes", {63'd0, errFlag}, 64'd0);
    // R3 shadow invisible before commit
    rd(2'd0, 6'd0, r);
    check("R3 read before commit shows old set", r, 64'd0);

    // R4 commit timing
    commitPulse();
    rd(2'd0, 6'd0, r);
    check("R4 read in cycle after commit still old", r, 64'd0);
    applyModelCommit();
    rd(2'd0, 6'd0, r);
    check("R4 read two cycles after commit new", r, expRead(2'd0, 6'd0));

    // R1 R2 R6 R11 read back each table entry
    for (int i = 0; i < NV; i++) begin
      rd(WTAB[i].bank, WTAB[i].phase, r);
      check($sformatf("R1 R2 R6 R11 table entry %0d", i), r, expRead(WTAB[i].bank, WTAB[i].phase));
    end
    rd(2'd3, 6'd20, r);
    check("R2 disabled halves not stored", r, {16'h4444, 16'h0000, 16'h0000, 16'h4441});
    rd(2'd0, 6'd7, r);
    check("R9 gated write left no data", r, 64'd0);
    rd(2'd1, 6'd0, r);
    check("R11 other bank untouched", r, 64'd0);
    rd(2'd2, 6'd32, r);
    check("R6 phase 32 direct", r, {16'h3334, 16'h3333, 16'h0, 16'h0});

    // R7 mirroring
    rd(2'd2, 6'd33, r);
    check("R7 phase 33 mirrors 31 reversed", r, {16'h5551, 16'h5552, 16'h5553, 16'h5554});
    rd(2'd1, 6'd63, r);
    check("R7 phase 63 mirrors 1 reversed", r, {16'h0, 16'h0, 16'h6663, 16'h6664});
    rd(2'd1, 6'd59, r);
    check("R7 phase 59 mirrors 5", r, expRead(2'd1, 6'd59));

    // R2 overwrite with even disabled, R3 before second commit
    wrPair('{2'd3, 6'd20, 1'b0, 1'b0, 16'h7777, 1'b1, 16'h7778});
    rd(2'd3, 6'd20, r);
    check("R3 active unchanged before second commit", r, {16'h4444, 16'h0000, 16'h0000, 16'h4441});
    commitPulse(); tick(); applyModelCommit();
    rd(2'd3, 6'd20, r);
    check("R2 even kept odd replaced", r, {16'h4444, 16'h0000, 16'h7778, 16'h4441});

    // R8 power-down
    pwrDisWr = 1; pwrDisVal = 0; tick(); pwrDisWr = 0;
    tick();
    check("R8 status gated after power-down", {63'd0, pwrState}, 64'd1);
    powered = 0;

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule